// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the integer arithmetic stage of a 32-bit pipelined core. Each cycle it may accept one decoded operation with two register operands, a 16-bit immediate and a flag that chooses between the register form and the immediate form. It produces a sum, a bitwise AND, or an upper-half immediate load. Each operation extends the immediate in its own way: sign extension for the signed add, zero extension for the unsigned add and the AND, and placement in the upper half for the upper-immediate load.

The result is formed combinationally and then captured in a single output register. A valid strobe follows the input strobe one cycle later. A signed-overflow flag is raised only by the signed add. An operation code the unit does not support gives a zero result and raises an illegal-operation flag. Instruction decode, register write-back, floating point, multiply and divide are handled elsewhere.

Top module: `int_exec_unit`

## Requirements
- R1: With op_code 3'd0 and imm_sel 0, the result is opnd_a + opnd_b, taken modulo 2^32.
- R2: With op_code 3'd0 and imm_sel 1, the result is opnd_a plus imm_val sign-extended to 32 bits, where bit 15 of imm_val is copied into bits 31:16.
- R3: With op_code 3'd1, the result is opnd_a + opnd_b when imm_sel is 0, and opnd_a plus imm_val zero-extended when imm_sel is 1.
- R4: For op_code 3'd0, in either form, ovf_flag is 1 exactly when both addends have the same bit 31 and the sum's bit 31 differs from it.
- R5: For op_code 3'd1, ovf_flag is always 0, including when the unsigned sum wraps.
- R6: With op_code 3'd2, the result is the bitwise AND of opnd_a with opnd_b when imm_sel is 0, and with imm_val zero-extended when imm_sel is 1.
- R7: With op_code 3'd3, the result is {imm_val, 16'h0000}. opnd_a, opnd_b and imm_sel have no effect on it.
- R8: op_code values 3'd4 to 3'd7 give a result of 0, bad_op 1 and ovf_flag 0. bad_op is 0 for codes 3'd0 to 3'd3.
- R9: out_valid equals in_valid from the previous cycle. The result and both flags are captured only in cycles where in_valid is 1, and they hold their values otherwise.
- R10: While rst is high, out_valid, result, ovf_flag and bad_op are cleared to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Decoded operation: 0 signed add, 1 unsigned add, 2 AND, 3 upper-immediate load |
| imm_sel | input | 1 | 1 selects the immediate form, 0 the register form |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm_val | input | 16 | Raw immediate |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Registered result |
| ovf_flag | output | 1 | Signed overflow of the signed add |
| bad_op | output | 1 | Unsupported operation code |

## Verification
The bench builds the unit with its default widths: a 32-bit datapath and a 16-bit immediate. At these widths a short directed list can reach the sign boundaries, such as 0x7FFFFFFF plus one, 0x80000000 plus itself, and immediates with bit 15 set. These cases separate sign extension from zero extension and signed overflow from unsigned wrap. Operations are issued back to back and then with gaps, so the one-cycle latency and the hold behaviour can both be checked.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OPC_ADD  = 3'd0;
    localparam logic [OP_W-1:0] OPC_ADDU = 3'd1;
    localparam logic [OP_W-1:0] OPC_AND  = 3'd2;
    localparam logic [OP_W-1:0] OPC_LUI  = 3'd3;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2,
        EXT_NONE  = 2'd3
    } ext_kind_e;

    typedef struct packed {
        logic ovf;
        logic illegal;
    } alu_flags_t;

    function automatic ext_kind_e ext_kind_of(input logic [OP_W-1:0] op);
        case (op)
            OPC_ADD:  return EXT_SIGN;
            OPC_ADDU: return EXT_ZERO;
            OPC_AND:  return EXT_ZERO;
            OPC_LUI:  return EXT_UPPER;
            default:  return EXT_NONE;
        endcase
    endfunction

    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return (op == OPC_ADD) || (op == OPC_ADDU) ||
               (op == OPC_AND) || (op == OPC_LUI);
    endfunction

endpackage

// File: rtl/imm_extender.sv
module imm_extender
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] imm_ext
);
    localparam int PAD_W = DATA_W - IMM_W;

    ext_kind_e kind;

    always_comb begin
        kind = ext_kind_of(op);
        case (kind)
            EXT_SIGN:  imm_ext = {{PAD_W{imm[IMM_W-1]}}, imm};
            EXT_ZERO:  imm_ext = {{PAD_W{1'b0}}, imm};
            EXT_UPPER: imm_ext = {imm, {PAD_W{1'b0}}};
            default:   imm_ext = '0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm_ext,
    output logic [DATA_W-1:0] value,
    output alu_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    logic              sign_ovf;

    always_comb begin
        b_eff    = use_imm ? imm_ext : b;
        sum      = a + b_eff;
        sign_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

    always_comb begin
        value         = '0;
        flags.ovf     = 1'b0;
        flags.illegal = !op_is_legal(op);
        case (op)
            OPC_ADD: begin
                value     = sum;
                flags.ovf = sign_ovf;
            end
            OPC_ADDU: value = sum;
            OPC_AND:  value = a & b_eff;
            OPC_LUI:  value = imm_ext;
            default:  value = '0;
        endcase
    end
endmodule

// File: rtl/alu_out_reg.sv
module alu_out_reg
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] value,
    input  alu_flags_t        flags,
    output logic              out_valid,
    output logic [DATA_W-1:0] value_q,
    output alu_flags_t        flags_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            value_q   <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                value_q <= value;
                flags_q <= flags;
            end
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf_flag,
    output logic              bad_op
);
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] comb_value;
    alu_flags_t        comb_flags;
    alu_flags_t        flags_q;

    imm_extender #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .op      (op_code),
        .imm     (imm_val),
        .imm_ext (imm_ext)
    );

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op      (op_code),
        .use_imm (imm_sel),
        .a       (opnd_a),
        .b       (opnd_b),
        .imm_ext (imm_ext),
        .value   (comb_value),
        .flags   (comb_flags)
    );

    alu_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .value     (comb_value),
        .flags     (comb_flags),
        .out_valid (out_valid),
        .value_q   (result),
        .flags_q   (flags_q)
    );

    assign ovf_flag = flags_q.ovf;
    assign bad_op   = flags_q.illegal;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        op_code,
    input logic [IMM_W-1:0]  imm_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              ovf_flag,
    input logic              bad_op
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(ovf_flag) && $stable(bad_op)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 3'd1) |=> !ovf_flag);

    // R8
    illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[2]) |=> (bad_op && !ovf_flag && result == '0));

    // R8
    legal_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_code[2]) |=> !bad_op);

    // R7
    upper_load_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 3'd3) |=>
            (result == {$past(imm_val), {(DATA_W-IMM_W){1'b0}}}));
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .imm_val   (imm_val),
    .out_valid (out_valid),
    .result    (result),
    .ovf_flag  (ovf_flag),
    .bad_op    (bad_op)
);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

    typedef struct {
        logic [31:0] value;
        logic        ovf;
        logic        illegal;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        imm_sel = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm_val = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_flag;
    logic        bad_op;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];
    exp_t last_exp;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .imm_sel(imm_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_val(imm_val),
        .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag), .bad_op(bad_op)
    );

    function automatic exp_t model(input logic [2:0] op, input logic sel,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [15:0] imm, input string req);
        exp_t e;
        logic [31:0] addend;
        logic [31:0] s;
        e.value = '0; e.ovf = 1'b0; e.illegal = 1'b0; e.req = req;
        case (op)
            3'd0: begin
                addend  = sel ? {{16{imm[15]}}, imm} : b;
                s       = a + addend;
                e.value = s;
                e.ovf   = (a[31] == addend[31]) && (s[31] != a[31]);
            end
            3'd1: e.value = a + (sel ? {16'h0, imm} : b);
            3'd2: e.value = a & (sel ? {16'h0, imm} : b);
            3'd3: e.value = {imm, 16'h0};
            default: e.illegal = 1'b1;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic sel, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] imm, input string req);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; imm_sel = sel;
        opnd_a = a; opnd_b = b; imm_val = imm;
        sb_q.push_back(model(op, sel, a, b, imm, req));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a = 32'hDEADBEEF; opnd_b = 32'h12345678; imm_val = 16'hA5A5; op_code = 3'd2;
    endtask

    // Monitor: pops the scoreboard whenever a result is presented
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                last_exp = e;
                check(result == e.value, e.req, "result", result, e.value);
                check(ovf_flag == e.ovf, e.req, "ovf_flag", {31'd0, ovf_flag}, {31'd0, e.ovf});
                check(bad_op == e.illegal, e.req, "bad_op", {31'd0, bad_op}, {31'd0, e.illegal});
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            check(1'b0, "watchdog", "timeout", 32'd1, 32'd0);
            finish_run();
        end
    end

    initial begin
        in_valid = 1'b1;
        op_code  = 3'd3; imm_val = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10", "out_valid", {31'd0, out_valid}, 32'd0);
        check(result == 32'd0, "R10", "result", result, 32'd0);
        check(!ovf_flag && !bad_op, "R10", "flags", {30'd0, ovf_flag, bad_op}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R1 register signed add
        drive(3'd0, 1'b0, 32'd5, 32'd7, 16'h0000, "R1");
        drive(3'd0, 1'b0, 32'hFFFFFFFF, 32'd1, 16'hFFFF, "R1");
        // R4 overflow in register form
        drive(3'd0, 1'b0, 32'h7FFFFFFF, 32'd1, 16'h0000, "R4");
        drive(3'd0, 1'b0, 32'h80000000, 32'h80000000, 16'h0000, "R4");
        // R2 sign-extended immediate
        drive(3'd0, 1'b1, 32'd10, 32'h55555555, 16'hFFFF, "R2");
        drive(3'd0, 1'b1, 32'h00010000, 32'd0, 16'h8000, "R2");
        // R4 overflow in immediate form
        drive(3'd0, 1'b1, 32'h7FFFFFFF, 32'd0, 16'h0001, "R4");
        drive(3'd0, 1'b1, 32'h80000000, 32'd0, 16'h8000, "R4");
        idle();
        // R3 unsigned add forms
        drive(3'd1, 1'b0, 32'h00001000, 32'h00000234, 16'h0000, "R3");
        drive(3'd1, 1'b1, 32'd0, 32'hFFFFFFFF, 16'h8000, "R3");
        // R5 no overflow on unsigned wrap or sign crossing
        drive(3'd1, 1'b0, 32'hFFFFFFFF, 32'd1, 16'h0000, "R5");
        drive(3'd1, 1'b1, 32'h7FFFFFFF, 32'd0, 16'h0001, "R5");
        drive(3'd1, 1'b0, 32'h80000000, 32'h80000000, 16'h0000, "R5");
        // R6 bitwise AND forms
        drive(3'd2, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, "R6");
        drive(3'd2, 1'b1, 32'hFFFFFFFF, 32'h00000000, 16'h8001, "R6");
        idle();
        idle();
        // R7 upper-immediate load ignores both operands and imm_sel
        drive(3'd3, 1'b0, 32'hCAFEF00D, 32'h13572468, 16'hFFD8, "R7");
        drive(3'd3, 1'b1, 32'h00000000, 32'hFFFFFFFF, 16'h0001, "R7");
        // R8 unsupported codes
        drive(3'd4, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h1234, "R8");
        drive(3'd7, 1'b1, 32'hFFFFFFFF, 32'd1, 16'hFFFF, "R8");
        drive(3'd5, 1'b0, 32'h12345678, 32'h9ABCDEF0, 16'h0000, "R8");
        idle();
        repeat (3) idle();
        // R9: outputs hold while in_valid is low
        check(out_valid == 1'b0, "R9", "out_valid idle", {31'd0, out_valid}, 32'd0);
        check(result == last_exp.value, "R9", "held result", result, last_exp.value);
        check(bad_op == last_exp.illegal, "R9", "held bad_op",
              {31'd0, bad_op}, {31'd0, last_exp.illegal});
        check(sb_q.size() == 0, "R9", "scoreboard drained", sb_q.size(), 32'd0);
        done = 1'b1;
        finish_run();
    end
endmodule